// File: doc/BRIEF.md
# Transparent-Mode Receive Character Filter

This block sits on the receive path of a character-oriented synchronous link, between the character deserializer and the receive buffer logic. For every received character it decides three things. It decides whether the character is written to the buffer. It decides whether the character counts toward the block check sequence (BCS). It decides whether the current buffer must be closed, and for what reason. In transparent mode a configurable escape character (DLE) starts a two-character sequence. The character after the escape is then interpreted by a small state machine.

Two 16-bit configuration words set the match characters. One holds the SYNC pattern together with a valid bit and a strip-disable bit. The other holds the DLE pattern and its valid bit. An eight-entry control table gives an action for escaped characters that are neither SYNC nor DLE. Each entry can either close the buffer as a normal end of frame or store the character and continue. The hunt-mode flag from the synchronizer does two things: it turns SYNC stripping off, and it cancels any escape that is still pending.

Top module: `bsc_rx_filter`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, all outputs are zero. A reset also discards a pending escape, so a control character received next is handled as plain data.
- R2: A character that is not consumed by any rule appears one cycle after `chr_vld` with `out_vld=1`, `bcs_inc=1` and `out_data` equal to the input character. A cycle without `chr_vld` produces no strobe.
- R3: In transparent mode (`xparent=1`), with the DLE valid bit (`dle_cfg[0]`) set and hunt low, a character equal to `dle_cfg[15:8]` is dropped and left out of the BCS, and the next character is treated as the escaped one.
- R4: An escaped character equal to `sync_cfg[15:8]` is dropped and left out of the BCS.
- R5: An escaped character equal to the DLE pattern is stored and counted in the BCS.
- R6: Any other escaped character is looked up in the control table. A hit on an entry whose action bit is 1 gives `close_pulse=1` with `close_why=2'b01` (normal end); the character is counted in the BCS but not stored. A hit on an entry whose action bit is 0 stores the character and counts it in the BCS. `close_why` is `2'b00` whenever `close_pulse` is low.
- R7: An escaped character that misses the table gives `close_pulse=1` with `close_why=2'b10` (escape-follow error). It is neither stored nor counted.
- R8: With the DLE valid bit clear, DLE characters are plain data.
- R9: With the SYNC valid bit (`sync_cfg[0]`) set and hunt low, an unescaped character equal to the SYNC pattern is dropped. With the valid bit clear, it is plain data.
- R10: The strip-disable bit (`sync_cfg[1]`) keeps SYNC characters as data in transparent mode only. In normal mode (`xparent=0`) it has no effect.
- R11: While `hunt` is high, every character is stored and counted without stripping or escape handling. Hunt also discards a pending escape.
- R12: In normal mode, DLE has no special meaning and no buffer close is ever raised.
- R13: Pattern matches compare all 8 bits, so a character that differs from a pattern only in bit 7 (the parity position) does not match.
- R14: Control table entries whose valid bit is clear never match. When several valid entries match, the lowest index decides the action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chr_vld | input | 1 | Received character strobe |
| chr_data | input | 8 | Received character |
| hunt | input | 1 | Receiver is hunting for synchronization |
| xparent | input | 1 | Transparent mode select |
| sync_cfg | input | 16 | [0] SYNC valid, [1] strip disable, [15:8] SYNC pattern |
| dle_cfg | input | 16 | [0] DLE valid, [15:8] DLE pattern |
| ctl_chr | input | 64 | Control table characters, entry i at [8i+7:8i] |
| ctl_vld | input | 8 | Control table entry valid bits |
| ctl_eof | input | 8 | Control table action: 1 close as end of frame, 0 store |
| out_vld | output | 1 | Write `out_data` to the buffer |
| out_data | output | 8 | Character to store |
| bcs_inc | output | 1 | Include the character in the BCS |
| close_pulse | output | 1 | Close the current buffer |
| close_why | output | 2 | Close reason: 01 normal end, 10 escape-follow error |

## Verification
The assertions check on every cycle the relations among the outputs themselves. A store always carries a BCS strobe and echoes the previous input. An error close never stores or counts. A normal close counts but does not store, and the reason code is quiet without a close. Idle cycles, hunt mode and normal mode also have fixed outcomes that the assertions track. Which rule fires for a given character depends on the escape state and on the configuration, so only the bench's sweeps show it. The bench sends every 8-bit value on its own and after an escape, across several configurations. Its directed sequences show that reset and hunt cancel a pending escape.

// File: rtl/bsc_rx_pkg.sv
package bsc_rx_pkg;

   typedef enum logic [1:0] {
      CLS_NONE    = 2'b00,
      CLS_EOF     = 2'b01,
      CLS_ESC_ERR = 2'b10
   } close_why_t;

   typedef enum logic {
      ESC_IDLE = 1'b0,
      ESC_PEND = 1'b1
   } esc_state_t;

   typedef struct packed {
      logic       store;
      logic       bcs;
      logic       close;
      close_why_t why;
   } verdict_t;

   localparam int unsigned CFG_FLAG_BITS = 8;

endpackage

// File: rtl/bsc_char_match.sv
module bsc_char_match #(
   parameter int unsigned CW = 8
) (
   input  logic [CW-1:0] pattern,
   input  logic [CW-1:0] chr,
   output logic          hit
);
   // full-width compare: parity position is part of the pattern
   assign hit = (pattern == chr);
endmodule

// File: rtl/bsc_ctl_lookup.sv
module bsc_ctl_lookup #(
   parameter int unsigned CW    = 8,
   parameter int unsigned TBL_N = 8
) (
   input  logic [TBL_N*CW-1:0] tbl_chr,
   input  logic [TBL_N-1:0]    tbl_vld,
   input  logic [TBL_N-1:0]    tbl_eof,
   input  logic [CW-1:0]       chr,
   output logic                hit,
   output logic                eof
);
   logic [TBL_N-1:0] ent_hit;

   for (genvar i = 0; i < TBL_N; i++) begin : g_ent
      logic raw;
      bsc_char_match #(.CW(CW)) u_cmp (
         .pattern (tbl_chr[i*CW +: CW]),
         .chr     (chr),
         .hit     (raw)
      );
      assign ent_hit[i] = raw & tbl_vld[i];
   end

   // lowest index wins
   always_comb begin
      hit = 1'b0;
      eof = 1'b0;
      for (int i = TBL_N - 1; i >= 0; i--) begin
         if (ent_hit[i]) begin
            hit = 1'b1;
            eof = tbl_eof[i];
         end
      end
   end
endmodule

// File: rtl/bsc_esc_fsm.sv
module bsc_esc_fsm
   import bsc_rx_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic     chr_vld,
   input  logic     hunt,
   input  logic     xparent,
   input  logic     sync_en,
   input  logic     sync_keep,
   input  logic     dle_en,
   input  logic     is_sync,
   input  logic     is_dle,
   input  logic     tbl_hit,
   input  logic     tbl_eof,
   output verdict_t verdict
);
   esc_state_t st, st_nxt;

   always_comb begin
      verdict = '0;
      st_nxt  = st;
      if (chr_vld) begin
         if (hunt) begin
            st_nxt        = ESC_IDLE;
            verdict.store = 1'b1;
            verdict.bcs   = 1'b1;
         end else if (xparent && st == ESC_PEND) begin
            st_nxt = ESC_IDLE;
            if (is_sync) begin
               verdict = '0;
            end else if (is_dle) begin
               verdict.store = 1'b1;
               verdict.bcs   = 1'b1;
            end else if (tbl_hit) begin
               if (tbl_eof) begin
                  verdict.bcs   = 1'b1;
                  verdict.close = 1'b1;
                  verdict.why   = CLS_EOF;
               end else begin
                  verdict.store = 1'b1;
                  verdict.bcs   = 1'b1;
               end
            end else begin
               verdict.close = 1'b1;
               verdict.why   = CLS_ESC_ERR;
            end
         end else if (xparent && dle_en && is_dle) begin
            st_nxt = ESC_PEND;
         end else if (sync_en && !(xparent && sync_keep) && is_sync) begin
            verdict = '0;
         end else begin
            verdict.store = 1'b1;
            verdict.bcs   = 1'b1;
         end
         if (!xparent) st_nxt = ESC_IDLE;
      end else if (hunt || !xparent) begin
         st_nxt = ESC_IDLE;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) st <= ESC_IDLE;
      else     st <= st_nxt;
   end
endmodule

// File: rtl/bsc_rx_filter.sv
module bsc_rx_filter
   import bsc_rx_pkg::*;
#(
   parameter int unsigned CW    = 8,
   parameter int unsigned TBL_N = 8,
   localparam int unsigned CFG_W = CFG_FLAG_BITS + CW
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                chr_vld,
   input  logic [CW-1:0]       chr_data,
   input  logic                hunt,
   input  logic                xparent,
   input  logic [CFG_W-1:0]    sync_cfg,
   input  logic [CFG_W-1:0]    dle_cfg,
   input  logic [TBL_N*CW-1:0] ctl_chr,
   input  logic [TBL_N-1:0]    ctl_vld,
   input  logic [TBL_N-1:0]    ctl_eof,
   output logic                out_vld,
   output logic [CW-1:0]       out_data,
   output logic                bcs_inc,
   output logic                close_pulse,
   output logic [1:0]          close_why
);
   if (CW < 5 || CW > 16) begin : g_bad_cw
      $error("bsc_rx_filter: CW must be 5..16");
   end
   if (TBL_N < 1 || TBL_N > 32) begin : g_bad_tbl
      $error("bsc_rx_filter: TBL_N must be 1..32");
   end

   logic rsvd_unused;
   assign rsvd_unused = ^{sync_cfg[CFG_FLAG_BITS-1:2], dle_cfg[CFG_FLAG_BITS-1:1]};

   logic     is_sync, is_dle, tbl_hit, tbl_eof;
   verdict_t verdict;

   bsc_char_match #(.CW(CW)) u_sync_cmp (
      .pattern (sync_cfg[CFG_W-1:CFG_FLAG_BITS]),
      .chr     (chr_data),
      .hit     (is_sync)
   );

   bsc_char_match #(.CW(CW)) u_dle_cmp (
      .pattern (dle_cfg[CFG_W-1:CFG_FLAG_BITS]),
      .chr     (chr_data),
      .hit     (is_dle)
   );

   bsc_ctl_lookup #(.CW(CW), .TBL_N(TBL_N)) u_tbl (
      .tbl_chr (ctl_chr),
      .tbl_vld (ctl_vld),
      .tbl_eof (ctl_eof),
      .chr     (chr_data),
      .hit     (tbl_hit),
      .eof     (tbl_eof)
   );

   bsc_esc_fsm u_fsm (
      .clk       (clk),
      .rst       (rst),
      .chr_vld   (chr_vld),
      .hunt      (hunt),
      .xparent   (xparent),
      .sync_en   (sync_cfg[0]),
      .sync_keep (sync_cfg[1]),
      .dle_en    (dle_cfg[0]),
      .is_sync   (is_sync),
      .is_dle    (is_dle),
      .tbl_hit   (tbl_hit),
      .tbl_eof   (tbl_eof),
      .verdict   (verdict)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_vld     <= 1'b0;
         out_data    <= '0;
         bcs_inc     <= 1'b0;
         close_pulse <= 1'b0;
         close_why   <= CLS_NONE;
      end else begin
         out_vld     <= verdict.store;
         bcs_inc     <= verdict.bcs;
         close_pulse <= verdict.close;
         close_why   <= verdict.why;
         if (chr_vld) out_data <= chr_data;
      end
   end
endmodule

// File: rtl/bsc_rx_filter_chk.sv
module bsc_rx_filter_chk #(
   parameter int unsigned CW = 8
) (
   input logic          clk,
   input logic          rst,
   input logic          chr_vld,
   input logic [CW-1:0] chr_data,
   input logic          hunt,
   input logic          xparent,
   input logic          out_vld,
   input logic [CW-1:0] out_data,
   input logic          bcs_inc,
   input logic          close_pulse,
   input logic [1:0]    close_why
);
   assert_store_counted_R2: assert property (@(posedge clk) disable iff (rst)
      out_vld |-> bcs_inc);

   assert_store_echo_R2: assert property (@(posedge clk) disable iff (rst)
      chr_vld |=> (!out_vld || out_data == $past(chr_data)));

   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
      !chr_vld |=> (!out_vld && !bcs_inc && !close_pulse));

   assert_eof_close_R6: assert property (@(posedge clk) disable iff (rst)
      (close_pulse && close_why == 2'b01) |-> (bcs_inc && !out_vld));

   assert_why_quiet_R6: assert property (@(posedge clk) disable iff (rst)
      !close_pulse |-> close_why == 2'b00);

   assert_err_drop_R7: assert property (@(posedge clk) disable iff (rst)
      (close_pulse && close_why == 2'b10) |-> (!out_vld && !bcs_inc));

   assert_hunt_pass_R11: assert property (@(posedge clk) disable iff (rst)
      (chr_vld && hunt) |=> (out_vld && bcs_inc && !close_pulse));

   assert_plain_no_close_R12: assert property (@(posedge clk) disable iff (rst)
      (chr_vld && !xparent) |=> !close_pulse);
endmodule

bind bsc_rx_filter bsc_rx_filter_chk #(.CW(CW)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .chr_vld     (chr_vld),
   .chr_data    (chr_data),
   .hunt        (hunt),
   .xparent     (xparent),
   .out_vld     (out_vld),
   .out_data    (out_data),
   .bcs_inc     (bcs_inc),
   .close_pulse (close_pulse),
   .close_why   (close_why)
);

// File: tb/bsc_rx_filter_test.sv
`timescale 1ns/1ps
module bsc_rx_filter_test;
   localparam int N = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          chr_vld = 1'b0;
   logic [7:0]    chr_data = 8'h00;
   logic          hunt = 1'b0;
   logic          xparent = 1'b1;
   logic [15:0]   sync_cfg, dle_cfg;
   logic [N*8-1:0] ctl_chr;
   logic [N-1:0]  ctl_vld, ctl_eof;
   logic          out_vld, bcs_inc, close_pulse;
   logic [7:0]    out_data;
   logic [1:0]    close_why;

   int tests = 0, fails = 0;
   bit done = 1'b0;

   // bench-side configuration
   logic [7:0] p_sync = 8'h32, p_dle = 8'h10;
   bit sv = 1, sdis = 0, dv = 1;
   logic [7:0] t_chr [N];
   bit         t_vld [N];
   bit         t_eof [N];
   bit         m_esc = 0;

   always #2.5 clk = ~clk;

   assign sync_cfg = {p_sync, 6'b0, sdis, sv};
   assign dle_cfg  = {p_dle, 7'b0, dv};
   for (genvar i = 0; i < N; i++) begin : g_tbl
      assign ctl_chr[i*8 +: 8] = t_chr[i];
      assign ctl_vld[i] = t_vld[i];
      assign ctl_eof[i] = t_eof[i];
   end

   bsc_rx_filter uut (
      .clk(clk), .rst(rst), .chr_vld(chr_vld), .chr_data(chr_data),
      .hunt(hunt), .xparent(xparent), .sync_cfg(sync_cfg), .dle_cfg(dle_cfg),
      .ctl_chr(ctl_chr), .ctl_vld(ctl_vld), .ctl_eof(ctl_eof),
      .out_vld(out_vld), .out_data(out_data), .bcs_inc(bcs_inc),
      .close_pulse(close_pulse), .close_why(close_why)
   );

   task automatic model(input bit v, input logic [7:0] c,
                        output bit st, output bit bc, output bit cl,
                        output logic [1:0] why, output string rq);
      st = 0; bc = 0; cl = 0; why = 2'b00; rq = "R2";
      if (!v) begin
         if (hunt || !xparent) m_esc = 0;
         return;
      end
      if (hunt) begin
         m_esc = 0; st = 1; bc = 1; rq = "R11";
      end else if (xparent && m_esc) begin
         m_esc = 0;
         if (c == p_sync) rq = "R4";
         else if (c == p_dle) begin st = 1; bc = 1; rq = "R5"; end
         else begin
            int hit;
            hit = -1;
            for (int i = 0; i < N; i++)
               if (hit < 0 && t_vld[i] && t_chr[i] == c) hit = i;
            if (hit >= 0) begin
               rq = "R6";
               if (t_eof[hit]) begin bc = 1; cl = 1; why = 2'b01; end
               else begin st = 1; bc = 1; end
            end else begin
               cl = 1; why = 2'b10; rq = "R7";
            end
         end
      end else if (xparent && dv && c == p_dle) begin
         m_esc = 1; rq = "R3";
      end else if (sv && !(xparent && sdis) && c == p_sync) begin
         rq = "R9";
      end else begin
         st = 1; bc = 1;
         if (c == p_dle) rq = xparent ? "R8" : "R12";
         else if (c == p_sync) rq = (xparent && sdis) ? "R10" : (sv ? "R10" : "R9");
         else rq = "R2";
      end
   endtask

   task automatic expect_out(input string rq, input bit st, input bit bc,
                             input bit cl, input logic [1:0] why, input logic [7:0] c);
      tests++;
      if (out_vld !== st || bcs_inc !== bc || close_pulse !== cl || close_why !== why ||
          (st && out_data !== c)) begin
         fails++;
         $display("FAIL %s chr=%02h: got vld=%0b bcs=%0b cls=%0b why=%0d data=%02h, exp vld=%0b bcs=%0b cls=%0b why=%0d data=%02h",
                  rq, c, out_vld, bcs_inc, close_pulse, close_why, out_data,
                  st, bc, cl, why, c);
      end
   endtask

   task automatic step(input bit v, input logic [7:0] c, input string tag = "");
      bit st, bc, cl; logic [1:0] why; string rq;
      chr_vld = v; chr_data = c;
      model(v, c, st, bc, cl, why, rq);
      @(negedge clk);
      expect_out(tag != "" ? tag : rq, st, bc, cl, why, c);
   endtask

   task automatic sweep();
      for (int c = 0; c < 256; c++) begin
         step(1, p_dle); step(1, c[7:0]); step(0, 8'h00);
      end
      for (int c = 0; c < 256; c++) step(1, c[7:0]);
      step(0, 8'h00);
   endtask

   initial begin
      for (int i = 0; i < N; i++) begin t_chr[i] = 8'h00; t_vld[i] = 0; t_eof[i] = 0; end
      t_chr[0] = 8'h03; t_vld[0] = 1; t_eof[0] = 1;
      t_chr[1] = 8'h05; t_vld[1] = 1; t_eof[1] = 0;
      t_chr[2] = 8'h03; t_vld[2] = 1; t_eof[2] = 0;
      t_chr[3] = 8'h26; t_vld[3] = 0; t_eof[3] = 1;
      repeat (3) @(negedge clk);
      expect_out("R1", 0, 0, 0, 2'b00, 8'h00);
      rst = 0;
      @(negedge clk);
      expect_out("R1", 0, 0, 0, 2'b00, 8'h00);

      // reset drops a pending escape (R1)
      step(1, p_dle);
      chr_vld = 0; rst = 1; @(negedge clk); rst = 0; m_esc = 0;
      step(1, 8'h03, "R1");

      // configuration sweeps
      sweep();                               // R2..R7, R9
      dv = 0; sweep(); dv = 1;               // R8
      sdis = 1; sweep();                     // R10
      xparent = 0; sweep(); xparent = 1;     // R12, R10 ignored
      sdis = 0; sv = 0; sweep(); sv = 1;     // R9 valid clear
      hunt = 1; sweep(); hunt = 0;           // R11

      // hunt cancels pending escape (R11)
      step(1, p_dle);
      hunt = 1; step(0, 8'h00); hunt = 0;
      step(1, 8'h03, "R11");

      // 8-bit compare (R13)
      step(1, p_sync | 8'h80, "R13");
      step(1, p_dle | 8'h80, "R13");
      step(1, p_dle); step(1, 8'h83, "R13");
      // table priority and invalid entry (R14)
      step(1, p_dle); step(1, 8'h03, "R14");
      step(1, p_dle); step(1, 8'h26, "R14");
      step(0, 8'h00);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: got timeout, exp completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule